// File: doc/BRIEF.md
# Programmable-Phase Symbol Sync Generator

This block produces one sync pulse per symbol for a receive path whose converter delivers two samples per symbol. A fast clock gives 48 ticks per symbol. The block finds the falling edge of a slower symbol clock in that fast domain and counts ticks from it. It raises the sync output a chosen number of ticks after that edge. The delay comes from a 6-bit phase select, so the pulse can sit at any of 48 evenly spaced positions in the symbol.

The rising edge of the pulse also latches the first 14-bit receive word of the symbol. A second word is latched a half symbol (24 ticks) later. Each latched word comes with a one-cycle valid flag. The phase select is read only at the reference edge, so a change made partway through a symbol takes effect in the next one. A select above 47 gives no pulse in that symbol. When the symbol clock edges stop arriving on the 48-tick grid, a one-cycle error pulse is raised.

The tick counter keeps running when no new falling edge arrives. It then produces another pulse every 48 cycles.

Top module: `sym_sync_gen`

## Requirements
- R1: The reference edge F is the first clk edge at which `sym_clk` is sampled low after being sampled high. With n the value of `phase_sel` sampled at F, `sync_out` rises after clk edge F+1+n.
- R2: Each sync pulse stays high for exactly 2 clk cycles.
- R3: `phase_sel` is sampled only at a reference edge. Changing it between reference edges does not move the pulse within the current symbol.
- R4: On the clk edge at which the sync pulse starts, `word0_q` captures `rx_word`. `word0_vld` is high for that one cycle only.
- R5: Exactly 24 clk edges after a sync pulse starts, `word1_q` captures `rx_word`. `word1_vld` is high for that one cycle only.
- R6: The tick counter wraps after 48 ticks. If no new reference edge arrives, a further pulse and capture pair starts 48 cycles after the previous one.
- R7: `align_err` goes high for one cycle after any reference edge whose spacing from the previous reference edge is not a multiple of 48 cycles. The first reference edge after reset never flags.
- R8: Reset clears every output to zero. No sync pulse, capture or error occurs before the first reference edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one tick per cycle (48 per symbol) |
| rst | input | 1 | Synchronous active-high reset |
| sym_clk | input | 1 | Symbol clock, already synchronous to clk |
| phase_sel | input | 6 | Sync delay in ticks after the reference edge (0..47) |
| rx_word | input | 14 | Receive sample from the converter |
| sync_out | output | 1 | Registered sync pulse |
| word0_q | output | 14 | First captured word of the symbol |
| word0_vld | output | 1 | One-cycle strobe for word0_q |
| word1_q | output | 14 | Second captured word of the symbol |
| word1_vld | output | 1 | One-cycle strobe for word1_q |
| align_err | output | 1 | One-cycle flag for an off-grid symbol clock edge |

## Verification
The embedded assertions check several properties on every cycle. The tick counter stays within range. The sync pulse is never shorter than two cycles. Each first-word strobe falls inside a high sync pulse. The valid and error flags last a single cycle. Nothing fires before the first reference edge. Only the bench scenarios can show the exact placement of the pulse for each phase, the tick-accurate timing and data of both captures, the deferred use of a changed phase select, the extra pulse from counter wrap during a long symbol, and the error pulse after short and long symbols.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  // Increment with wrap at modulus m (result stays in 0..m-1).
  function automatic int wrap_inc(int v, int m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/ssg_phase_cnt.sv
module ssg_phase_cnt #(
  parameter int TICKS = 48,
  localparam int CW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sym_clk,
  input  logic [CW-1:0] phase_sel,
  output logic          locked,
  output logic          start,
  output logic          align_err
);
  import ssg_pkg::*;

  logic          sym_d;
  logic          fall;
  logic [CW-1:0] cnt;
  logic [CW-1:0] phase_q;

  assign fall  = sym_d & ~sym_clk;
  assign start = locked & (cnt == phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_d     <= 1'b0;
      cnt       <= '0;
      phase_q   <= '0;
      locked    <= 1'b0;
      align_err <= 1'b0;
    end else begin
      sym_d     <= sym_clk;
      // spacing is on-grid only when the counter sits on its last tick
      align_err <= fall & locked & (cnt != CW'(TICKS - 1));
      if (fall) begin
        cnt     <= '0;
        phase_q <= phase_sel;
        locked  <= 1'b1;
      end else begin
        cnt <= CW'(wrap_inc(int'(cnt), TICKS));
      end
    end
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TICKS - 1));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
    align_err |=> !align_err);

endmodule

// File: rtl/ssg_pulse.sv
module ssg_pulse #(
  parameter int PULSE_TICKS = 2,
  localparam int PW = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sync_out
);
  logic [PW-1:0] pw;

  always_ff @(posedge clk) begin
    if (rst) begin
      pw       <= '0;
      sync_out <= 1'b0;
    end else if (start) begin
      pw       <= PW'(PULSE_TICKS);
      sync_out <= 1'b1;
    end else begin
      if (pw != '0) pw <= pw - PW'(1);
      sync_out <= (pw > PW'(1));
    end
  end

  assert_min_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |=> sync_out);

endmodule

// File: rtl/ssg_capture.sv
module ssg_capture #(
  parameter int DATA_W     = 14,
  parameter int SECOND_OFS = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] word0_q,
  output logic              word0_vld,
  output logic [DATA_W-1:0] word1_q,
  output logic              word1_vld
);
  // one bit per tick of delay: overlapping symbols never lose a capture
  logic [SECOND_OFS-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly       <= '0;
      word0_q   <= '0;
      word0_vld <= 1'b0;
      word1_q   <= '0;
      word1_vld <= 1'b0;
    end else begin
      dly       <= {dly[SECOND_OFS-2:0], start};
      word0_vld <= start;
      word1_vld <= dly[SECOND_OFS-1];
      if (start)            word0_q <= rx_word;
      if (dly[SECOND_OFS-1]) word1_q <= rx_word;
    end
  end

  assert_w1_single_R5: assert property (@(posedge clk) disable iff (rst)
    word1_vld |=> !word1_vld);

endmodule

// File: rtl/sym_sync_gen.sv
module sym_sync_gen #(
  parameter int TICKS       = 48,
  parameter int DATA_W      = 14,
  parameter int PULSE_TICKS = 2,
  parameter int SECOND_OFS  = 24,
  localparam int CW = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_clk,
  input  logic [CW-1:0]     phase_sel,
  input  logic [DATA_W-1:0] rx_word,
  output logic              sync_out,
  output logic [DATA_W-1:0] word0_q,
  output logic              word0_vld,
  output logic [DATA_W-1:0] word1_q,
  output logic              word1_vld,
  output logic              align_err
);
  logic locked;
  logic start;

  ssg_phase_cnt #(.TICKS(TICKS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .sym_clk   (sym_clk),
    .phase_sel (phase_sel),
    .locked    (locked),
    .start     (start),
    .align_err (align_err)
  );

  ssg_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sync_out (sync_out)
  );

  ssg_capture #(.DATA_W(DATA_W), .SECOND_OFS(SECOND_OFS)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rx_word   (rx_word),
    .word0_q   (word0_q),
    .word0_vld (word0_vld),
    .word1_q   (word1_q),
    .word1_vld (word1_vld)
  );

  assert_w0_in_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    word0_vld |-> sync_out);

  assert_quiet_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (!sync_out && !word0_vld && !word1_vld && !align_err));

endmodule

// File: tb/sym_sync_gen_bench.sv
module sym_sync_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        sym_clk;
  logic [5:0]  phase_sel;
  logic [13:0] rx_word = '0;
  logic        sync_out, word0_vld, word1_vld, align_err;
  logic [13:0] word0_q, word1_q;

  sym_sync_gen u_sym_sync_gen (
    .clk(clk), .rst(rst), .sym_clk(sym_clk), .phase_sel(phase_sel),
    .rx_word(rx_word), .sync_out(sync_out), .word0_q(word0_q),
    .word0_vld(word0_vld), .word1_q(word1_q), .word1_vld(word1_vld),
    .align_err(align_err)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int edge_cnt = 0;
  int last_fall = -1;
  int n_rise = 0;
  int run = 0;
  bit mon_on = 0;
  bit prev_s = 0;
  bit done = 0;

  int          q_sync[$], q_w0[$], q_w1[$], q_err[$];
  logic [13:0] qv_w0[$], qv_w1[$];

  function automatic logic [13:0] pat(int e);
    return 14'(e * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (edge %0d)", req, act, exp, edge_cnt);
    end
  endtask

  always @(posedge clk) edge_cnt <= edge_cnt + 1;
  always @(negedge clk) rx_word <= pat(edge_cnt + 1);

  // driver: one symbol period, pushes its expected events
  task automatic run_period(input int ph, input int len, input bit poke);
    int f;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        f = edge_cnt + 1;
        sym_clk = 1'b0;
        phase_sel = 6'(ph);
        if (last_fall >= 0 && ((f - last_fall) % 48) != 0) q_err.push_back(f);
        for (int e = f + 1; e <= f + len; e++) begin
          if (((e - f - 1) % 48) == ph) begin
            q_sync.push_back(e);
            q_w0.push_back(e);  qv_w0.push_back(pat(e));
            q_w1.push_back(e + 24); qv_w1.push_back(pat(e + 24));
          end
        end
        last_fall = f;
      end else begin
        if (i == len / 2) sym_clk = 1'b1;
        if (poke && i == 3) phase_sel = 6'((ph + 17) % 48); // R3 mid-symbol change
      end
    end
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    int e;
    logic [13:0] v;
    if (mon_on) begin
      if (sync_out && !prev_s) begin
        n_rise++;
        if (q_sync.size() == 0) chk(0, "R1 unexpected sync", edge_cnt, -1);
        else begin e = q_sync.pop_front(); chk(edge_cnt == e, "R1 sync rise", edge_cnt, e); end
      end
      if (sync_out) run++;
      else begin
        if (run != 0) chk(run == 2, "R2 pulse width", run, 2);
        run = 0;
      end
      if (word0_vld) begin
        if (q_w0.size() == 0) chk(0, "R4 unexpected word0", edge_cnt, -1);
        else begin
          e = q_w0.pop_front(); v = qv_w0.pop_front();
          chk(edge_cnt == e, "R4 word0 time", edge_cnt, e);
          chk(word0_q == v, "R4 word0 data", word0_q, v);
        end
      end
      if (word1_vld) begin
        if (q_w1.size() == 0) chk(0, "R5 unexpected word1", edge_cnt, -1);
        else begin
          e = q_w1.pop_front(); v = qv_w1.pop_front();
          chk(edge_cnt == e, "R5 word1 time", edge_cnt, e);
          chk(word1_q == v, "R5 word1 data", word1_q, v);
        end
      end
      if (align_err) begin
        if (q_err.size() == 0) chk(0, "R7 unexpected align_err", edge_cnt, -1);
        else begin e = q_err.pop_front(); chk(edge_cnt == e, "R7 align_err time", edge_cnt, e); end
      end
    end
    prev_s = sync_out;
  end

  initial begin
    int rec;
    rst = 1'b1; sym_clk = 1'b1; phase_sel = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sync_out == 0,   "R8 reset sync_out", sync_out, 0);
    chk(word0_vld == 0,  "R8 reset word0_vld", word0_vld, 0);
    chk(word1_vld == 0,  "R8 reset word1_vld", word1_vld, 0);
    chk(align_err == 0,  "R8 reset align_err", align_err, 0);
    chk(word0_q == 0,    "R8 reset word0_q", word0_q, 0);
    chk(word1_q == 0,    "R8 reset word1_q", word1_q, 0);
    mon_on = 1;
    repeat (60) @(negedge clk); // R8: no events before first reference edge
    run_period(0, 48, 0);
    run_period(5, 48, 0);
    run_period(47, 48, 0);
    run_period(12, 48, 1);      // R3: phase_sel poked mid-symbol
    run_period(30, 48, 0);
    run_period(3, 40, 0);       // short symbol, R7 at next edge
    rec = n_rise;
    run_period(5, 56, 0);       // long symbol: R6 wrap gives a second pulse
    @(posedge clk);
    chk(n_rise - rec == 2, "R6 pulses in long symbol", n_rise - rec, 2);
    run_period(25, 48, 0);      // R7 flagged for 56-cycle spacing
    run_period(40, 48, 0);
    repeat (30) @(negedge clk);
    mon_on = 0;
    chk(q_sync.size() == 0, "R1 missing sync", q_sync.size(), 0);
    chk(q_w0.size() == 0,   "R4 missing word0", q_w0.size(), 0);
    chk(q_w1.size() == 0,   "R5 missing word1", q_w1.size(), 0);
    chk(q_err.size() == 0,  "R7 missing align_err", q_err.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", edge_cnt, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule